// File: doc/BRIEF.md
# Masked Multiplicity Majority Trigger

This block forms the trigger decisions for a group of sixteen discriminated hit lines. An enable mask gates each line. The gated lines feed two things: a global OR, and a count of how many enabled channels are active in the current cycle. That count is compared against a programmable majority level, and the majority output goes high when the level is exceeded.

Several copies of the block can be chained so that together they make one global majority decision. Each copy takes an unsigned multiplicity value from the copy upstream. In external mode it adds its own count to that value, caps the result at the bus maximum, passes the total downstream and compares the total against its level. In internal mode the upstream value is ignored, and only the local count is compared and exported.

The mask and the level are written through a simple one-cycle write port. All outputs are registered and appear one clock after the inputs that produced them.

Top module: `mtrig_top`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `or_o`, `maj_o` and `chain_out_o` are 0. After reset every channel is enabled (mask all ones) and the level is 0.
- R2: Mask bit i set to 1 enables channel i. A disabled channel contributes to neither the OR nor the count.
- R3: `or_o` is 1 exactly when at least one enabled channel was high in the previous cycle.
- R4: In internal mode (`ext_mode_i`=0), `chain_out_o` equals the number of enabled channels that were high, and `chain_in_i` has no effect.
- R5: In external mode (`ext_mode_i`=1), `chain_out_o` equals the local count plus `chain_in_i`, capped at 127 rather than wrapping.
- R6: With a nonzero level, `maj_o` is 1 exactly when the exported total (the value `chain_out_o` shows in the same cycle) is strictly greater than the level.
- R7: With a level of 0, `maj_o` equals `or_o`. An upstream value alone does not raise it.
- R8: Every output reflects the inputs of the previous cycle. A configuration write takes effect for hits presented in the cycle after the write; hits in the same cycle as the write use the old setting.
- R9: A write with `wr_addr_i`=0 loads `wr_data_i` into the mask. A write with `wr_addr_i`=1 loads `wr_data_i[6:0]` into the level, and bits 15:7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_i | input | 16 | Discriminated hit lines, one per channel |
| ext_mode_i | input | 1 | 1 selects chained (external) majority, 0 selects local |
| chain_in_i | input | 7 | Multiplicity from the upstream module |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_addr_i | input | 1 | 0 selects the mask, 1 selects the level |
| wr_data_i | input | 16 | Configuration write data |
| or_o | output | 1 | Registered OR of enabled hits |
| maj_o | output | 1 | Registered majority decision |
| chain_out_o | output | 7 | Registered multiplicity passed downstream |

## Verification
Two events can fall in the same cycle: a configuration write, and the evaluation of hits against the setting that write is replacing. The bench provokes this both in directed cases and at random. It writes a mask that disables the very channels that are high in that cycle, and it writes a new level while hits are present. It expects the old setting in the following cycle and the new one after that. A second overlap is cap and majority together: a large upstream value plus many local hits must cap at 127 and still compare correctly against a high level.

// File: rtl/mtrig_pkg.sv
package mtrig_pkg;

    localparam int DEF_NUM_CH = 16;
    localparam int DEF_CNT_W  = 7;
    localparam int DEF_LVL_W  = 7;

    typedef enum logic {
        CFG_MASK  = 1'b0,
        CFG_LEVEL = 1'b1
    } cfg_addr_e;

    typedef struct packed {
        logic                  any_hit;
        logic                  majority;
        logic [DEF_CNT_W-1:0]  total;
    } trig_out_t;

endpackage

// File: rtl/mtrig_cfg.sv
module mtrig_cfg
    import mtrig_pkg::*;
#(
    parameter int NUM_CH = DEF_NUM_CH,
    parameter int LVL_W  = DEF_LVL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [NUM_CH-1:0] wr_data,
    output logic [NUM_CH-1:0] enable,
    output logic [LVL_W-1:0]  level
);

    cfg_addr_e sel;
    assign sel = cfg_addr_e'(wr_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            enable <= '1;
            level  <= '0;
        end else if (wr_en) begin
            case (sel)
                CFG_MASK:  enable <= wr_data;
                CFG_LEVEL: level  <= wr_data[LVL_W-1:0];
                default:   ;
            endcase
        end
    end

endmodule

// File: rtl/mtrig_count.sv
module mtrig_count #(
    parameter int NUM_CH = 16,
    parameter int CNT_W  = 7
) (
    input  logic [NUM_CH-1:0] hit,
    input  logic [NUM_CH-1:0] enable,
    output logic              any_hit,
    output logic [CNT_W-1:0]  count
);

    logic [NUM_CH-1:0] gated;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_gate
        assign gated[ch] = hit[ch] & enable[ch];
    end

    assign any_hit = |gated;

    always_comb begin
        count = '0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            count = count + CNT_W'(gated[ch]);
        end
    end

endmodule

// File: rtl/mtrig_chain.sv
module mtrig_chain #(
    parameter int CNT_W = 7,
    parameter int LVL_W = 7
) (
    input  logic             ext_mode,
    input  logic             any_hit,
    input  logic [CNT_W-1:0] local_cnt,
    input  logic [CNT_W-1:0] chain_in,
    input  logic [LVL_W-1:0] level,
    output logic [CNT_W-1:0] total,
    output logic             majority
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W:0]   wide_sum;
    logic [CNT_W-1:0] capped;

    assign wide_sum = {1'b0, local_cnt} + {1'b0, chain_in};
    assign capped   = wide_sum[CNT_W] ? CNT_MAX : wide_sum[CNT_W-1:0];
    assign total    = ext_mode ? capped : local_cnt;

    always_comb begin
        if (level == '0) begin
            majority = any_hit;
        end else begin
            majority = int'(total) > int'(level);
        end
    end

endmodule

// File: rtl/mtrig_top.sv
module mtrig_top
    import mtrig_pkg::*;
#(
    parameter int NUM_CH = DEF_NUM_CH,
    parameter int CNT_W  = DEF_CNT_W,
    parameter int LVL_W  = DEF_LVL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] hit_i,
    input  logic              ext_mode_i,
    input  logic [CNT_W-1:0]  chain_in_i,
    input  logic              wr_en_i,
    input  logic              wr_addr_i,
    input  logic [NUM_CH-1:0] wr_data_i,
    output logic              or_o,
    output logic              maj_o,
    output logic [CNT_W-1:0]  chain_out_o
);

    logic [NUM_CH-1:0] cfg_en;
    logic [LVL_W-1:0]  cfg_lvl;
    logic              any_hit;
    logic [CNT_W-1:0]  local_cnt;
    logic [CNT_W-1:0]  total;
    logic              majority;

    mtrig_cfg #(.NUM_CH(NUM_CH), .LVL_W(LVL_W)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en_i),
        .wr_addr (wr_addr_i),
        .wr_data (wr_data_i),
        .enable  (cfg_en),
        .level   (cfg_lvl)
    );

    mtrig_count #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_count (
        .hit     (hit_i),
        .enable  (cfg_en),
        .any_hit (any_hit),
        .count   (local_cnt)
    );

    mtrig_chain #(.CNT_W(CNT_W), .LVL_W(LVL_W)) u_chain (
        .ext_mode  (ext_mode_i),
        .any_hit   (any_hit),
        .local_cnt (local_cnt),
        .chain_in  (chain_in_i),
        .level     (cfg_lvl),
        .total     (total),
        .majority  (majority)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            or_o        <= 1'b0;
            maj_o       <= 1'b0;
            chain_out_o <= '0;
        end else begin
            or_o        <= any_hit;
            maj_o       <= majority;
            chain_out_o <= total;
        end
    end

endmodule

// File: rtl/mtrig_chk.sv
module mtrig_chk #(
    parameter int NUM_CH = 16,
    parameter int CNT_W  = 7,
    parameter int LVL_W  = 7
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_CH-1:0] hit_i,
    input logic              ext_mode_i,
    input logic [CNT_W-1:0]  chain_in_i,
    input logic              or_o,
    input logic              maj_o,
    input logic [CNT_W-1:0]  chain_out_o,
    input logic [NUM_CH-1:0] enable,
    input logic [LVL_W-1:0]  level
);

    logic armed;

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    // R1: outputs held low during reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (!or_o && !maj_o && chain_out_o == '0));

    // R3 with R2: OR follows gated hits of previous cycle
    p_or_gated_r3: assert property (@(posedge clk) disable iff (rst || !armed)
        or_o == (|($past(hit_i) & $past(enable))));

    // R4: local count never exceeds channel count
    p_local_cap_r4: assert property (@(posedge clk) disable iff (rst || !armed)
        !$past(ext_mode_i) |-> (int'(chain_out_o) <= NUM_CH));

    // R5: chained total never below upstream value
    p_ext_floor_r5: assert property (@(posedge clk) disable iff (rst || !armed)
        $past(ext_mode_i) |-> (chain_out_o >= $past(chain_in_i)));

    // R6: local majority requires a local hit
    p_maj_needs_hit_r6: assert property (@(posedge clk) disable iff (rst || !armed)
        (!$past(ext_mode_i) && maj_o) |-> or_o);

    // R7: level zero makes majority track the OR
    p_lvl_zero_r7: assert property (@(posedge clk) disable iff (rst || !armed)
        ($past(level) == '0) |-> (maj_o == or_o));

endmodule

bind mtrig_top mtrig_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .LVL_W(LVL_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .hit_i       (hit_i),
    .ext_mode_i  (ext_mode_i),
    .chain_in_i  (chain_in_i),
    .or_o        (or_o),
    .maj_o       (maj_o),
    .chain_out_o (chain_out_o),
    .enable      (cfg_en),
    .level       (cfg_lvl)
);

// File: tb/mtrig_top_tb.sv
`timescale 1ns/1ps
module mtrig_top_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] hit_i;
    logic        ext_mode_i;
    logic [6:0]  chain_in_i;
    logic        wr_en_i;
    logic        wr_addr_i;
    logic [15:0] wr_data_i;
    logic        or_o;
    logic        maj_o;
    logic [6:0]  chain_out_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic done = 1'b0;

    logic [15:0] m_en;
    logic [6:0]  m_lvl;

    always #2.5 clk = ~clk;

    mtrig_top u_dut (
        .clk(clk), .rst(rst), .hit_i(hit_i), .ext_mode_i(ext_mode_i),
        .chain_in_i(chain_in_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .or_o(or_o), .maj_o(maj_o), .chain_out_o(chain_out_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 50000 && !done) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_count(input logic [15:0] h, input logic [15:0] en);
        int n = 0;
        for (int i = 0; i < 16; i++) if (h[i] && en[i]) n++;
        return n;
    endfunction

    function automatic int exp_total(input int cnt, input logic ext, input logic [6:0] cin);
        int t;
        if (!ext) return cnt;
        t = cnt + int'(cin);
        return (t > 127) ? 127 : t;
    endfunction

    // One cycle: drive at negedge, check at the following negedge.
    task automatic cyc(input logic [15:0] h, input logic ext, input logic [6:0] cin,
                       input logic we, input logic wa, input logic [15:0] wd, input string tag);
        int cnt, tot, e_or, e_maj;
        cnt   = exp_count(h, m_en);
        tot   = exp_total(cnt, ext, cin);
        e_or  = (cnt > 0) ? 1 : 0;
        e_maj = (m_lvl == 0) ? e_or : ((tot > int'(m_lvl)) ? 1 : 0);
        hit_i = h; ext_mode_i = ext; chain_in_i = cin;
        wr_en_i = we; wr_addr_i = wa; wr_data_i = wd;
        if (we) begin
            if (!wa) m_en = wd;
            else     m_lvl = wd[6:0];
        end
        @(negedge clk);
        check({tag, "/R3"}, "or_o", int'(or_o), e_or);
        check({tag, ext ? "/R5" : "/R4"}, "chain_out_o", int'(chain_out_o), tot);
        check({tag, (m_lvl == 0 && !(we && wa)) || (we && wa) ? "/R7R6" : "/R6"}, "maj_o", int'(maj_o), e_maj);
        wr_en_i = 1'b0;
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd2024);
        rst = 1'b1; hit_i = '0; ext_mode_i = 1'b0; chain_in_i = '0;
        wr_en_i = 1'b0; wr_addr_i = 1'b0; wr_data_i = '0;
        m_en = '1; m_lvl = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "or_o in reset", int'(or_o), 0);
        check("R1", "maj_o in reset", int'(maj_o), 0);
        check("R1", "chain_out_o in reset", int'(chain_out_o), 0);
        rst = 1'b0;

        // R1: reset config is all enabled, level 0
        cyc(16'hFFFF, 1'b0, 7'd0, 1'b0, 1'b0, '0, "R1");
        cyc(16'h0000, 1'b0, 7'd0, 1'b0, 1'b0, '0, "R1");

        // R2: disable low byte, hits only there
        cyc(16'h0000, 1'b0, 7'd0, 1'b1, 1'b0, 16'hFF00, "R2");
        cyc(16'h00FF, 1'b0, 7'd0, 1'b0, 1'b0, '0, "R2");
        cyc(16'h0F0F, 1'b0, 7'd0, 1'b0, 1'b0, '0, "R2");

        // R4: upstream ignored in internal mode
        cyc(16'h0300, 1'b0, 7'd100, 1'b0, 1'b0, '0, "R4");

        // R9: level write with junk upper bits -> level 3
        cyc(16'h0000, 1'b0, 7'd0, 1'b1, 1'b1, 16'hFF83, "R9");
        cyc(16'h0700, 1'b0, 7'd0, 1'b0, 1'b0, '0, "R9");
        cyc(16'h0F00, 1'b0, 7'd0, 1'b0, 1'b0, '0, "R6");

        // R8: write mask disabling the active channels in the same cycle
        cyc(16'hF000, 1'b0, 7'd0, 1'b1, 1'b0, 16'h0FFF, "R8");
        cyc(16'hF000, 1'b0, 7'd0, 1'b0, 1'b0, '0, "R8");

        // R5: saturation and majority at high level
        cyc(16'h0000, 1'b1, 7'd0, 1'b1, 1'b0, 16'hFFFF, "R5");
        cyc(16'h0000, 1'b1, 7'd0, 1'b1, 1'b1, 16'd126, "R5");
        cyc(16'hFFFF, 1'b1, 7'd120, 1'b0, 1'b0, '0, "R5");
        cyc(16'h0001, 1'b1, 7'd125, 1'b0, 1'b0, '0, "R5");
        cyc(16'h0003, 1'b1, 7'd127, 1'b0, 1'b0, '0, "R5");

        // R7: level zero, upstream only does not raise majority
        cyc(16'h0000, 1'b1, 7'd0, 1'b1, 1'b1, 16'd0, "R7");
        cyc(16'h0000, 1'b1, 7'd50, 1'b0, 1'b0, '0, "R7");
        cyc(16'h0010, 1'b1, 7'd50, 1'b0, 1'b0, '0, "R7");

        // R6: external mode crossing at level boundary
        cyc(16'h0000, 1'b1, 7'd0, 1'b1, 1'b1, 16'd10, "R6");
        cyc(16'h0003, 1'b1, 7'd7, 1'b0, 1'b0, '0, "R6");
        cyc(16'h0007, 1'b1, 7'd7, 1'b0, 1'b0, '0, "R6");

        // Random mix, writes included
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] h, wd;
            logic ext, we, wa;
            logic [6:0] cin;
            h   = 16'($urandom);
            ext = 1'($urandom);
            cin = 7'($urandom);
            we  = (($urandom % 8) == 0);
            wa  = 1'($urandom);
            wd  = wa ? 16'($urandom % 20) : 16'($urandom);
            cyc(h, ext, cin, we, wa, wd, "RND");
        end

        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule